// File: doc/BRIEF.md
# S/T Link Activation Controller

This block is the hardware state machine that brings an S/T subscriber link up and takes it down again. It runs either as the terminal end (TE) or as the network end (NT), chosen by a static personality input. The line receiver sits outside the block and supplies it with decoded events: which kind of signal is arriving (silence, the activation pattern, or framed traffic), a strobe once per frame period with a flag saying whether that frame met the violation-based framing rule, the received A bit, a strobe for each received bit with a flag for marks, and a 1 ms tick.

From these events the block chooses which Info signal the transmitter should send and reports a 2-bit state code. It also drives a status bit that shows either frame sync or bus activity, and a terminal reset output that goes low after a long run of received marks. Line coding, the analog front end and timing recovery lie outside the block.

Top module: `link_act_ctrl`

## Requirements
- R1: While reset is held and on release, state_o is 00, tx_info_o is 0 (Info0) and te_rst_no is 1.
- R2: In TE personality, state 00 moves to 01 on the next clock when act_req_i=1 and deact_req_i=0. In state 01, tx_info_o is 1 (Info1) while rx_info_i=0 (silence) and 0 (Info0) for any other rx_info_i value.
- R3: Frame sync is true once three successive frame_tick_i strobes have each come with frame_ok_i=1. A strobe with frame_ok_i=0 clears it. The state machine acts on sync one clock after the third good strobe.
- R4: In TE personality, state 01 with sync goes to 10, which sends Info3 (tx_info_o=3). State 10 goes to 11 when rx_a_i=1. State 11 (also Info3) goes back to 10 when rx_a_i=0. Loss of sync in 10 or 11 goes to 01.
- R5: In NT personality, state 00 moves to 01 when deact_req_i=0 and either act_req_i=1 or rx_info_i=1 (Info1 received). State 01 sends Info2 (tx_info_o=2).
- R6: In NT personality, state 01 goes to 11 when sync holds and rx_info_i=2 (framed signal). State 11 sends Info4 (tx_info_o=4) and falls back to 01 on loss of sync.
- R7: deact_req_i=1 sends a TE in any state to 00 on the next clock. In NT personality it sends states 01 and 11 to 10, which transmits Info0.
- R8: An NT in state 10 returns to 00 on the 32nd ms_tick_i counted after entering 10, and not before.
- R9: At each frame_tick_i the block registers act_req_i AND NOT deact_req_i. While that registered value is 1, sync_ba_o shows frame sync. While it is 0, sync_ba_o shows bus activity (rx_info_i not 0).
- R10: In TE personality, te_rst_no is 0 while the last 128 or more bit_tick_i strobes all carried rx_mark_i=1. A strobe with rx_mark_i=0 restarts the run. In NT personality, te_rst_no is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nt_mode_i | input | 1 | 1 = network end, 0 = terminal end |
| act_req_i | input | 1 | Activation request |
| deact_req_i | input | 1 | Deactivation request |
| rx_info_i | input | 2 | Received signal: 0 silence, 1 Info1 pattern, 2 framed, 3 other activity |
| frame_tick_i | input | 1 | One strobe per frame period |
| frame_ok_i | input | 1 | Frame met the framing criterion (qualifies frame_tick_i) |
| rx_a_i | input | 1 | Received A bit |
| ms_tick_i | input | 1 | 1 ms time strobe |
| bit_tick_i | input | 1 | One strobe per received bit |
| rx_mark_i | input | 1 | Received bit was a mark (qualifies bit_tick_i) |
| tx_info_o | output | 3 | Info type to send: 0..4 = Info0..Info4 |
| sync_ba_o | output | 1 | Sync or bus-activity status |
| state_o | output | 2 | 00 idle, 01 pending/request, 10 synced/pending off, 11 active |
| te_rst_no | output | 1 | Terminal reset, active low |

## Verification
Directed sequences drive each personality through its whole handshake. The TE run switches the line between silence and framed activity while it requests activation, which separates gated Info1 from Info0. It then steps the A bit high, low and high again to separate the A-driven moves from the sync-driven ones. Frames are fed as two good strobes followed by a bad one, then as three good ones, to find where sync is declared. On the NT side, ms ticks are counted to just below the timeout and then to exactly the timeout. The status selector is toggled between frame strobes to show that its change waits for the next frame, and a mark run of 127 broken by a space, then a full 128, checks the reset threshold. Randomized stretches in both personalities follow, compared cycle by cycle against a behavioural model.

// File: rtl/link_act_pkg.sv
package link_act_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_MID  = 2'b10,
    ST_UP   = 2'b11
  } lac_state_e;

  typedef enum logic [2:0] {
    TX_I0 = 3'd0,
    TX_I1 = 3'd1,
    TX_I2 = 3'd2,
    TX_I3 = 3'd3,
    TX_I4 = 3'd4
  } tx_info_e;

  localparam logic [1:0] RX_NONE   = 2'd0;
  localparam logic [1:0] RX_INFO1  = 2'd1;
  localparam logic [1:0] RX_FRAMED = 2'd2;
endpackage

// File: rtl/lac_sync_qual.sv
module lac_sync_qual #(
  parameter int N_FRAMES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_tick_i,
  input  logic frame_ok_i,
  output logic sync_o
);
  localparam int W = $clog2(N_FRAMES + 1);
  localparam logic [W-1:0] LIM = W'(N_FRAMES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (frame_tick_i) begin
      if (!frame_ok_i)      cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sync_o = (cnt_q == LIM);
endmodule

// File: rtl/lac_mark_run.sv
module lac_mark_run #(
  parameter int RUN_LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic mark_i,
  output logic hit_o
);
  localparam int W = $clog2(RUN_LEN + 1);
  localparam logic [W-1:0] LIM = W'(RUN_LEN);

  logic [W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (bit_tick_i) begin
      if (!mark_i)           run_q <= '0;
      else if (run_q != LIM) run_q <= run_q + 1'b1;
    end
  end

  assign hit_o = (run_q == LIM);
endmodule

// File: rtl/lac_fsm.sv
module lac_fsm
  import link_act_pkg::*;
#(
  parameter int TIMEOUT_MS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nt_mode_i,
  input  logic       act_req_i,
  input  logic       deact_req_i,
  input  logic [1:0] rx_info_i,
  input  logic       sync_i,
  input  logic       rx_a_i,
  input  logic       ms_tick_i,
  output lac_state_e state_o,
  output tx_info_e   tx_info_o
);
  localparam int TW = (TIMEOUT_MS > 1) ? $clog2(TIMEOUT_MS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_MS - 1);

  lac_state_e st_q, st_d;
  logic [TW-1:0] ms_q;
  logic          in_wait;
  logic          expire;

  assign in_wait = nt_mode_i && (st_q == ST_MID);
  assign expire  = in_wait && ms_tick_i && (ms_q == T_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ms_q <= '0;
    else if (!in_wait)  ms_q <= '0;
    else if (ms_tick_i) ms_q <= ms_q + 1'b1;
  end

  always_comb begin
    st_d = st_q;
    if (!nt_mode_i) begin
      unique case (st_q)
        ST_IDLE: if (act_req_i && !deact_req_i) st_d = ST_REQ;
        ST_REQ: begin
          if (deact_req_i) st_d = ST_IDLE;
          else if (sync_i) st_d = ST_MID;
        end
        ST_MID: begin
          if (deact_req_i)  st_d = ST_IDLE;
          else if (!sync_i) st_d = ST_REQ;
          else if (rx_a_i)  st_d = ST_UP;
        end
        ST_UP: begin
          if (deact_req_i)  st_d = ST_IDLE;
          else if (!sync_i) st_d = ST_REQ;
          else if (!rx_a_i) st_d = ST_MID;
        end
        default: st_d = ST_IDLE;
      endcase
    end else begin
      unique case (st_q)
        ST_IDLE:
          if (!deact_req_i && (act_req_i || rx_info_i == RX_INFO1)) st_d = ST_REQ;
        ST_REQ: begin
          if (deact_req_i) st_d = ST_MID;
          else if (sync_i && rx_info_i == RX_FRAMED) st_d = ST_UP;
        end
        ST_UP: begin
          if (deact_req_i)  st_d = ST_MID;
          else if (!sync_i) st_d = ST_REQ;
        end
        ST_MID: if (expire) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    tx_info_o = TX_I0;
    if (!nt_mode_i) begin
      unique case (st_q)
        ST_REQ:       tx_info_o = (rx_info_i == RX_NONE) ? TX_I1 : TX_I0;
        ST_MID, ST_UP: tx_info_o = TX_I3;
        default:      tx_info_o = TX_I0;
      endcase
    end else begin
      unique case (st_q)
        ST_REQ:  tx_info_o = TX_I2;
        ST_UP:   tx_info_o = TX_I4;
        default: tx_info_o = TX_I0;
      endcase
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/link_act_ctrl.sv
module link_act_ctrl
  import link_act_pkg::*;
#(
  parameter int SYNC_FRAMES = 3,
  parameter int TIMEOUT_MS  = 32,
  parameter int MARK_RUN    = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nt_mode_i,
  input  logic       act_req_i,
  input  logic       deact_req_i,
  input  logic [1:0] rx_info_i,
  input  logic       frame_tick_i,
  input  logic       frame_ok_i,
  input  logic       rx_a_i,
  input  logic       ms_tick_i,
  input  logic       bit_tick_i,
  input  logic       rx_mark_i,
  output logic [2:0] tx_info_o,
  output logic       sync_ba_o,
  output logic [1:0] state_o,
  output logic       te_rst_no
);
  logic       sync;
  logic       run_hit;
  logic       show_sync_q;
  lac_state_e st;
  tx_info_e   tx;

  lac_sync_qual #(.N_FRAMES(SYNC_FRAMES)) u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_tick_i (frame_tick_i),
    .frame_ok_i   (frame_ok_i),
    .sync_o       (sync)
  );

  lac_mark_run #(.RUN_LEN(MARK_RUN)) u_marks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .mark_i     (rx_mark_i),
    .hit_o      (run_hit)
  );

  lac_fsm #(.TIMEOUT_MS(TIMEOUT_MS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nt_mode_i   (nt_mode_i),
    .act_req_i   (act_req_i),
    .deact_req_i (deact_req_i),
    .rx_info_i   (rx_info_i),
    .sync_i      (sync),
    .rx_a_i      (rx_a_i),
    .ms_tick_i   (ms_tick_i),
    .state_o     (st),
    .tx_info_o   (tx)
  );

  // status meaning switches only at a frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           show_sync_q <= 1'b0;
    else if (frame_tick_i) show_sync_q <= act_req_i && !deact_req_i;
  end

  assign sync_ba_o = show_sync_q ? sync : (rx_info_i != RX_NONE);
  assign state_o   = st;
  assign tx_info_o = tx;
  assign te_rst_no = nt_mode_i || !run_hit;
endmodule

// File: rtl/link_act_ctrl_chk.sv
module link_act_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       nt_mode_i,
  input logic       deact_req_i,
  input logic [1:0] rx_info_i,
  input logic       rx_a_i,
  input logic       ms_tick_i,
  input logic [2:0] tx_info_o,
  input logic [1:0] state_o,
  input logic       te_rst_no
);
  p_info1_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_info_o == 3'd1) |-> (rx_info_i == 2'd0));

  p_te_up_on_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nt_mode_i && state_o == 2'b11 && $past(state_o) != 2'b11) |-> $past(rx_a_i));

  p_te_deact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nt_mode_i && deact_req_i) |=> (state_o == 2'b00));

  p_nt_deact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nt_mode_i && deact_req_i && state_o[0]) |=> (state_o == 2'b10));

  p_timeout_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nt_mode_i && state_o == 2'b00 && $past(state_o) == 2'b10) |-> $past(ms_tick_i));

  p_nt_no_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nt_mode_i |-> te_rst_no);
endmodule

bind link_act_ctrl link_act_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .nt_mode_i   (nt_mode_i),
  .deact_req_i (deact_req_i),
  .rx_info_i   (rx_info_i),
  .rx_a_i      (rx_a_i),
  .ms_tick_i   (ms_tick_i),
  .tx_info_o   (tx_info_o),
  .state_o     (state_o),
  .te_rst_no   (te_rst_no)
);

// File: tb/link_act_ctrl_tb.sv
module link_act_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nt = 1'b0, act = 1'b0, deact = 1'b0;
  logic [1:0] rx = 2'd0;
  logic ftick = 1'b0, fok = 1'b0, ra = 1'b0, mst = 1'b0, btick = 1'b0, mark = 1'b0;
  logic [2:0] tx_o;
  logic sb_o, rst_o;
  logic [1:0] st_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  link_act_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .nt_mode_i(nt), .act_req_i(act),
    .deact_req_i(deact), .rx_info_i(rx), .frame_tick_i(ftick),
    .frame_ok_i(fok), .rx_a_i(ra), .ms_tick_i(mst), .bit_tick_i(btick),
    .rx_mark_i(mark), .tx_info_o(tx_o), .sync_ba_o(sb_o), .state_o(st_o),
    .te_rst_no(rst_o)
  );

  // behavioural reference
  int m_st, m_frames, m_ms, m_marks, m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_frames = 0; m_ms = 0; m_marks = 0; m_sel = 0;
    end else begin
      int nx;
      bit insync;
      insync = (m_frames >= 3);
      nx = m_st;
      if (!nt) begin
        if (m_st == 0) begin
          if (act && !deact) nx = 1;
        end else if (deact) nx = 0;
        else if (m_st == 1) begin
          if (insync) nx = 2;
        end else if (!insync) nx = 1;
        else if (m_st == 2 && ra) nx = 3;
        else if (m_st == 3 && !ra) nx = 2;
      end else begin
        case (m_st)
          0: if (!deact && (act || rx == 2'd1)) nx = 1;
          1: if (deact) nx = 2; else if (insync && rx == 2'd2) nx = 3;
          3: if (deact) nx = 2; else if (!insync) nx = 1;
          default: if (mst && m_ms == 31) nx = 0;
        endcase
      end
      if (nt && m_st == 2) m_ms = mst ? m_ms + 1 : m_ms;
      else m_ms = 0;
      m_st = nx;
      if (ftick) begin
        m_frames = fok ? ((m_frames < 3) ? m_frames + 1 : 3) : 0;
        m_sel = (act && !deact) ? 1 : 0;
      end
      if (btick) m_marks = mark ? ((m_marks < 128) ? m_marks + 1 : 128) : 0;
    end
  end

  function automatic int exp_tx();
    if (!nt) begin
      if (m_st == 1) return (rx == 2'd0) ? 1 : 0;
      if (m_st >= 2) return 3;
      return 0;
    end
    if (m_st == 1) return 2;
    if (m_st == 3) return 4;
    return 0;
  endfunction

  task automatic chk(input int actv, input int expv, input string tag);
    n_chk++;
    if (actv != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actv, expv, $time);
    end
  endtask

  task automatic compare();
    int sb;
    sb = m_sel ? int'(m_frames >= 3) : int'(rx != 2'd0);
    chk(int'(st_o), m_st, "state R2,R4,R5,R6,R7,R8");
    chk(int'(tx_o), exp_tx(), "tx info R2,R4,R5,R6,R7");
    chk(int'(sb_o), sb, "status R3,R9");
    chk(int'(rst_o), (nt || m_marks < 128) ? 1 : 0, "reset out R10");
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    compare();
  endtask

  task automatic frame(input logic ok);
    ftick = 1'b1; fok = ok; cyc(); ftick = 1'b0; fok = 1'b0;
  endtask

  task automatic ms_pulse();
    mst = 1'b1; cyc(); mst = 1'b0; cyc();
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; nt = mode; act = 0; deact = 0; rx = 0; ra = 0;
    ftick = 0; fok = 0; mst = 0; btick = 0; mark = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(1'b0);
    chk(int'(st_o), 0, "R1 state");
    chk(int'(tx_o), 0, "R1 tx");
    chk(int'(rst_o), 1, "R1 reset out");

    // R2: TE request, Info1 gated by activity
    act = 1; cyc();
    chk(int'(st_o), 1, "R2 state");
    chk(int'(tx_o), 1, "R2 Info1 on quiet line");
    rx = 2'd2; #1;
    chk(int'(tx_o), 0, "R2 Info0 under activity");

    // R3: two good frames, a bad one, then three good
    frame(1); frame(1); frame(0); cyc();
    chk(int'(st_o), 1, "R3 no sync after broken run");
    frame(1); frame(1); frame(1);
    chk(int'(st_o), 1, "R3 sync not yet acted on");
    cyc();
    chk(int'(st_o), 2, "R3 sync acted on");
    chk(int'(tx_o), 3, "R4 Info3 when synced");
    chk(int'(sb_o), 1, "R9 status shows sync");

    // R4: A bit steps
    ra = 1; cyc(); chk(int'(st_o), 3, "R4 up on A=1");
    ra = 0; cyc(); chk(int'(st_o), 2, "R4 back on A=0");
    ra = 1; cyc(); chk(int'(st_o), 3, "R4 up again");
    frame(0); cyc(); chk(int'(st_o), 1, "R4 sync loss");

    // R9: selector change waits for a frame tick
    act = 0; cyc();
    chk(int'(sb_o), 0, "R9 still sync meaning");
    frame(1);
    chk(int'(sb_o), 1, "R9 activity meaning");

    // R7: TE deactivation
    act = 1; deact = 1; cyc();
    chk(int'(st_o), 0, "R7 TE to idle");
    deact = 0; act = 0; rx = 0; cyc();

    // R10: mark runs
    for (int i = 0; i < 127; i++) begin btick = 1; mark = 1; cyc(); end
    btick = 0; cyc();
    chk(int'(rst_o), 1, "R10 127 marks");
    btick = 1; mark = 0; cyc();
    for (int i = 0; i < 128; i++) begin btick = 1; mark = 1; cyc(); end
    btick = 0; cyc();
    chk(int'(rst_o), 0, "R10 128 marks");

    // NT personality
    do_reset(1'b1);
    chk(int'(rst_o), 1, "R10 NT reset high");
    rx = 2'd1; cyc();
    chk(int'(st_o), 1, "R5 Info1 starts NT");
    chk(int'(tx_o), 2, "R5 Info2");
    rx = 2'd2;
    frame(1); frame(1); frame(1); cyc();
    chk(int'(st_o), 3, "R6 active");
    chk(int'(tx_o), 4, "R6 Info4");
    frame(0); cyc();
    chk(int'(st_o), 1, "R6 sync loss");
    frame(1); frame(1); frame(1); cyc();
    chk(int'(st_o), 3, "R6 active again");
    deact = 1; cyc(); deact = 0;
    chk(int'(st_o), 2, "R7 NT pending off");
    chk(int'(tx_o), 0, "R7 Info0");
    for (int i = 0; i < 31; i++) ms_pulse();
    chk(int'(st_o), 2, "R8 before timeout");
    mst = 1; cyc(); mst = 0;
    chk(int'(st_o), 0, "R8 timeout");
    for (int i = 0; i < 200; i++) begin btick = 1; mark = 1; cyc(); end
    btick = 0; cyc();
    chk(int'(rst_o), 1, "R10 NT ignores marks");

    // randomized stretches, both personalities
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int i = 0; i < 3000; i++) begin
        act   = ($urandom_range(0, 9) < 7);
        deact = ($urandom_range(0, 49) == 0);
        rx    = 2'($urandom_range(0, 3));
        ftick = ($urandom_range(0, 3) == 0);
        fok   = ($urandom_range(0, 9) != 0);
        ra    = ($urandom_range(0, 3) != 0);
        mst   = ($urandom_range(0, 2) == 0);
        btick = 1'b1;
        mark  = ($urandom_range(0, 199) != 0);
        cyc();
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule